// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block turns faults seen anywhere in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) into precise traps. Fetch, decode, execute and memory may each flag a fault and give a one-bit cause for the instruction they hold that cycle. The block keeps, for every instruction in flight, a small status record: its valid bit, its PC, one fault bit for each reporting stage and one cause bit for each reporting stage. That record moves one stage at a time along with the instruction. A fault does not act when it is raised. It acts only when its instruction is the one in writeback. So the oldest faulting instruction always wins, even when a younger instruction faulted earlier in time.

In the cycle the trap is taken, the block does four things. It holds back the register-file write of the faulting instruction and the store of the instruction behind it. It raises a flush so that every younger pipeline latch is zeroed. It pulses the save strobes for the exception PC and the cause. On the next cycle it presents a fetch redirect to either a shared handler entry or a per-cause entry. A return-from-trap input sends fetch back to the saved PC and also flushes the in-flight instructions. The datapath and the handler code are outside this block.

Top module: `precise_trap_unit`

## Requirements
- R1: After a synchronous reset there is nothing in flight. `redirect_vld`, `epc`, `cause`, `flush`, `epc_we` and `cause_we` are all 0. Write requests are not passed to `rf_we` or `mem_we` until a valid instruction reaches the stage that issues them.
- R2: A fault flagged on an instruction in any reporting stage takes no action until that instruction is in writeback. An instruction fetched in cycle c traps in cycle c+4.
- R3: Traps are serviced in program order. Suppose an older instruction faults in execute after a younger one has already faulted in fetch. The trap records the older instruction's PC and cause.
- R4: When one instruction is flagged by several stages, the cause kept is the one from its earliest stage. The order is fetch, then decode, then execute, then memory.
- R5: `rf_we` follows `rf_we_req` only while the writeback instruction is valid and carries no fault.
- R6: `mem_we` is held low when any of these holds: the memory-stage instruction carries a fault, including a fault flagged by memory in that same cycle; the writeback instruction is trapping; a return-from-trap is being taken. Otherwise `mem_we` follows `mem_we_req` while the memory-stage instruction is valid.
- R7: A taken trap asserts `flush` and removes every younger instruction in flight. None of them traps or writes afterwards.
- R8: `epc_we` and `cause_we` are high in exactly the trap cycle. From the next cycle `epc` holds the faulting PC and `cause` holds the cause code (0 = undefined instruction, 1 = arithmetic overflow).
- R9: With `vec_mode` = 0, the cycle after a trap shows `redirect_vld` = 1 and `redirect_pc` = 0x80000180, whatever the cause. `redirect_vld` drops in the following cycle.
- R10: With `vec_mode` = 1, the redirect targets 0xC0000000 for cause 0 and 0xC0000020 for cause 1.
- R11: `eret` asserts `flush`, leaves `epc` unchanged, and gives `redirect_vld` = 1 with `redirect_pc` = `epc` on the next cycle. If a trap is taken in the same cycle, the trap's redirect wins.
- R12: Fault flags raised on a stage that holds no valid instruction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_vld | input | 1 | Fetch stage holds a valid instruction |
| if_pc | input | 32 | PC of the fetch-stage instruction |
| exc_vld | input | 4 | Fault flag per stage (bit 0 fetch, 1 decode, 2 execute, 3 memory) |
| exc_cause | input | 4 | Cause bit per stage, same bit order (0 undefined, 1 overflow) |
| vec_mode | input | 1 | 1 selects per-cause handler entries |
| eret | input | 1 | Return-from-trap request from writeback |
| rf_we_req | input | 1 | Register write request of the writeback instruction |
| mem_we_req | input | 1 | Store request of the memory-stage instruction |
| rf_we | output | 1 | Gated register-file write enable |
| mem_we | output | 1 | Gated memory write enable |
| flush | output | 1 | Zero all younger pipeline latches at this edge |
| epc_we | output | 1 | Exception PC save strobe |
| cause_we | output | 1 | Cause save strobe |
| epc | output | 32 | Saved exception PC |
| cause | output | 1 | Saved cause code |
| redirect_vld | output | 1 | Fetch redirect valid |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
Some properties are checked by assertions on every cycle: a flushed latch is empty on the next cycle, a memory-stage fault never goes out with a store, a trap lasts a single cycle and is always followed by a redirect, and the exception PC only changes when its save strobe is high. Several behaviours span more than one instruction and can only be shown by the bench's scenarios: oldest-first ordering when a younger instruction faulted first, the choice of cause when one instruction is flagged by several stages, the handler addresses in both modes, and the precedence of a trap over a return in the same cycle.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  typedef enum logic {
    EXC_UNDEF = 1'b0,
    EXC_OVF   = 1'b1
  } exc_cause_e;
endpackage

// File: rtl/ptu_stage_latch.sv
module ptu_stage_latch #(
  parameter int XLEN = 32,
  parameter int NREP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            in_vld,
  input  logic [XLEN-1:0] in_pc,
  input  logic [NREP-1:0] in_hit,
  input  logic [NREP-1:0] in_cau,
  output logic            q_vld,
  output logic [XLEN-1:0] q_pc,
  output logic [NREP-1:0] q_hit,
  output logic [NREP-1:0] q_cau
);
  // One pipeline slot of the status record; a kill zeroes the whole slot.
  always_ff @(posedge clk) begin
    if (rst || kill) begin
      q_vld <= 1'b0;
      q_pc  <= '0;
      q_hit <= '0;
      q_cau <= '0;
    end else begin
      q_vld <= in_vld;
      q_pc  <= in_pc;
      q_hit <= in_hit;
      q_cau <= in_cau;
    end
  end

  AST_KILL_EMPTIES_SLOT: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!q_vld && q_hit == '0)); // R7
endmodule

// File: rtl/ptu_oldest_pick.sv
module ptu_oldest_pick #(
  parameter int NREP = 4
) (
  input  logic [NREP-1:0] hit,
  input  logic [NREP-1:0] cau,
  output logic            any,
  output logic            cause
);
  // Earliest reporting stage of a single instruction decides its cause.
  always_comb begin
    any   = |hit;
    cause = 1'b0;
    for (int i = NREP - 1; i >= 0; i--) begin
      if (hit[i]) cause = cau[i];
    end
  end
endmodule

// File: rtl/ptu_handler_sel.sv
module ptu_handler_sel
  import ptu_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] COMMON_VEC = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic            vec_mode,
  input  logic            cause,
  output logic [XLEN-1:0] addr
);
  always_comb begin
    if (!vec_mode) begin
      addr = COMMON_VEC;
    end else if (exc_cause_e'(cause) == EXC_OVF) begin
      addr = VEC_BASE + VEC_STRIDE;
    end else begin
      addr = VEC_BASE;
    end
  end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit #(
  parameter int              XLEN       = 32,
  parameter int              NST        = 5,
  parameter logic [XLEN-1:0] COMMON_VEC = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              if_vld,
  input  logic [XLEN-1:0]   if_pc,
  input  logic [NST-2:0]    exc_vld,
  input  logic [NST-2:0]    exc_cause,
  input  logic              vec_mode,
  input  logic              eret,
  input  logic              rf_we_req,
  input  logic              mem_we_req,
  output logic              rf_we,
  output logic              mem_we,
  output logic              flush,
  output logic              epc_we,
  output logic              cause_we,
  output logic [XLEN-1:0]   epc,
  output logic              cause,
  output logic              redirect_vld,
  output logic [XLEN-1:0]   redirect_pc
);
  localparam int NREP   = NST - 1;  // stages able to report a fault
  localparam int MEM_IX = NST - 2;
  localparam int WB_IX  = NST - 1;

  logic            s_vld [NST];
  logic [XLEN-1:0] s_pc  [NST];
  logic [NREP-1:0] s_hit [NST];
  logic [NREP-1:0] s_cau [NST];
  logic [NREP-1:0] m_hit [NREP];
  logic [NREP-1:0] m_cau [NREP];

  logic            wb_any;
  logic            wb_cause;
  logic            take;
  logic [XLEN-1:0] handler;
  logic [XLEN-1:0] epc_q;
  logic            cause_q;
  logic            rdr_vld_q;
  logic [XLEN-1:0] rdr_pc_q;

  assign s_vld[0] = if_vld;
  assign s_pc[0]  = if_pc;
  assign s_hit[0] = '0;
  assign s_cau[0] = '0;

  // Merge this cycle's fault flags into each instruction's record.
  always_comb begin
    for (int k = 0; k < NREP; k++) begin
      m_hit[k] = s_hit[k];
      m_cau[k] = s_cau[k];
      m_hit[k][k] = s_hit[k][k] | exc_vld[k];
      m_cau[k][k] = exc_vld[k] ? exc_cause[k] : s_cau[k][k];
      if (!s_vld[k]) begin
        m_hit[k] = '0;
        m_cau[k] = '0;
      end
    end
  end

  for (genvar g = 1; g < NST; g++) begin : g_slot
    ptu_stage_latch #(.XLEN(XLEN), .NREP(NREP)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .kill   (flush),
      .in_vld (s_vld[g-1]),
      .in_pc  (s_pc[g-1]),
      .in_hit (m_hit[g-1]),
      .in_cau (m_cau[g-1]),
      .q_vld  (s_vld[g]),
      .q_pc   (s_pc[g]),
      .q_hit  (s_hit[g]),
      .q_cau  (s_cau[g])
    );
  end

  ptu_oldest_pick #(.NREP(NREP)) u_pick (
    .hit   (s_hit[WB_IX]),
    .cau   (s_cau[WB_IX]),
    .any   (wb_any),
    .cause (wb_cause)
  );

  ptu_handler_sel #(
    .XLEN(XLEN), .COMMON_VEC(COMMON_VEC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_hsel (
    .vec_mode (vec_mode),
    .cause    (wb_cause),
    .addr     (handler)
  );

  assign take     = s_vld[WB_IX] & wb_any;
  assign flush    = take | eret;
  assign epc_we   = take;
  assign cause_we = take;

  assign rf_we  = rf_we_req & s_vld[WB_IX] & ~wb_any;
  assign mem_we = mem_we_req & s_vld[MEM_IX] & ~(|m_hit[MEM_IX]) & ~take & ~eret;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q     <= '0;
      cause_q   <= 1'b0;
      rdr_vld_q <= 1'b0;
      rdr_pc_q  <= '0;
    end else begin
      if (take) begin
        epc_q   <= s_pc[WB_IX];
        cause_q <= wb_cause;
      end
      rdr_vld_q <= take | eret;
      if (take) begin
        rdr_pc_q <= handler;
      end else if (eret) begin
        rdr_pc_q <= epc_q;
      end
    end
  end

  assign epc          = epc_q;
  assign cause        = cause_q;
  assign redirect_vld = rdr_vld_q;
  assign redirect_pc  = rdr_pc_q;

  AST_TRAP_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst)
    epc_we |-> s_vld[WB_IX]); // R2
  AST_NO_STORE_ON_MEM_FAULT: assert property (@(posedge clk) disable iff (rst)
    (s_vld[MEM_IX] && exc_vld[MEM_IX]) |-> !mem_we); // R6
  AST_NO_WRITE_AFTER_TRAP: assert property (@(posedge clk) disable iff (rst)
    epc_we |=> !rf_we); // R7
  AST_TRAP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    epc_we |=> !epc_we); // R8
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    epc_we |=> (epc == $past(s_pc[WB_IX]))); // R8
  AST_REDIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    flush |=> redirect_vld); // R9
  AST_EPC_HELD: assert property (@(posedge clk) disable iff (rst)
    !epc_we |=> $stable(epc)); // R11
endmodule

// File: tb/test_precise_trap_unit.sv
module test_precise_trap_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        if_vld;
  logic [31:0] if_pc;
  logic [3:0]  exc_vld;
  logic [3:0]  exc_cause;
  logic        vec_mode;
  logic        eret;
  logic        rf_we_req;
  logic        mem_we_req;
  logic        rf_we, mem_we, flush, epc_we, cause_we, cause, redirect_vld;
  logic [31:0] epc, redirect_pc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  precise_trap_unit i_precise_trap_unit (
    .clk(clk), .rst(rst), .if_vld(if_vld), .if_pc(if_pc),
    .exc_vld(exc_vld), .exc_cause(exc_cause), .vec_mode(vec_mode), .eret(eret),
    .rf_we_req(rf_we_req), .mem_we_req(mem_we_req), .rf_we(rf_we), .mem_we(mem_we),
    .flush(flush), .epc_we(epc_we), .cause_we(cause_we), .epc(epc), .cause(cause),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
  );

  // {stage[1:0], cause, vec_mode, expected handler[31:0]}
  localparam logic [35:0] ROWS [8] = '{
    {2'd0, 1'b0, 1'b0, 32'h8000_0180},
    {2'd1, 1'b1, 1'b0, 32'h8000_0180},
    {2'd2, 1'b1, 1'b1, 32'hC000_0020},
    {2'd3, 1'b0, 1'b1, 32'hC000_0000},
    {2'd0, 1'b1, 1'b1, 32'hC000_0020},
    {2'd1, 1'b0, 1'b1, 32'hC000_0000},
    {2'd2, 1'b0, 1'b0, 32'h8000_0180},
    {2'd3, 1'b1, 1'b0, 32'h8000_0180}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [31:0] pc, input logic [3:0] ev,
                       input logic [3:0] ec, input logic rq, input logic mq, input logic er);
    if_vld = iv; if_pc = pc; exc_vld = ev; exc_cause = ec;
    rf_we_req = rq; mem_we_req = mq; eret = er;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [1:0]  st;
    logic        cz;
    logic [31:0] exp_addr;
    logic [31:0] pc;
    int          bad;
    rst = 1'b1; vec_mode = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) tick();
    rst = 1'b0;

    // R1: reset state
    drive(0, 0, 0, 0, 1, 1, 0);
    check("R1", "redirect_vld", 32'(redirect_vld), 0);
    check("R1", "epc", epc, 0);
    check("R1", "cause", 32'(cause), 0);
    check("R1", "flush", 32'(flush), 0);
    check("R1", "rf_we", 32'(rf_we), 0);
    check("R1", "mem_we", 32'(mem_we), 0);
    check("R1", "epc_we", 32'(epc_we), 0);
    tick();

    // Table: one fault per row, checked through trap and redirect (R2 R5 R6 R8 R9 R10)
    for (int r = 0; r < 8; r++) begin
      {st, cz, vec_mode, exp_addr} = ROWS[r];
      pc = 32'h1000 + 32'(r) * 16;
      for (int cy = 0; cy < 5; cy++) begin
        logic [3:0] ev;
        logic [3:0] ec;
        ev = '0; ec = '0;
        if (cy == int'(st)) begin ev[st] = 1'b1; ec[st] = cz; end
        drive(cy == 0, pc, ev, ec, cy == 4, cy == 3, 0);
        if (cy == 3) begin
          check("R6", "mem_we on faulting instr", 32'(mem_we), 0);
          check("R2", "epc_we before WB", 32'(epc_we), 0);
        end
        if (cy == 4) begin
          check("R8", "epc_we in WB", 32'(epc_we), 1);
          check("R8", "cause_we in WB", 32'(cause_we), 1);
          check("R7", "flush in WB", 32'(flush), 1);
          check("R5", "rf_we of faulting instr", 32'(rf_we), 0);
        end
        tick();
      end
      drive(0, 0, 0, 0, 0, 0, 0);
      check(vec_mode ? "R10" : "R9", "redirect_vld", 32'(redirect_vld), 1);
      check(vec_mode ? "R10" : "R9", "redirect_pc", redirect_pc, exp_addr);
      check("R8", "epc", epc, pc);
      check("R8", "cause", 32'(cause), 32'(cz));
      tick();
      check("R9", "redirect_vld drops", 32'(redirect_vld), 0);
    end
    vec_mode = 1'b0;

    // R5 R6: clean instruction writes normally
    drive(1, 32'h200, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick(); tick();
    drive(0, 0, 0, 0, 0, 1, 0);
    check("R6", "mem_we clean", 32'(mem_we), 1);
    tick();
    drive(0, 0, 0, 0, 1, 0, 0);
    check("R5", "rf_we clean", 32'(rf_we), 1);
    check("R2", "no trap clean", 32'(epc_we), 0);
    tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R9", "no redirect clean", 32'(redirect_vld), 0);

    // R3: younger faults first in time, older wins
    drive(1, 32'h300, 0, 0, 0, 0, 0); tick();
    drive(1, 32'h304, 4'b0001, 4'b0000, 0, 0, 0); tick();
    drive(1, 32'h308, 4'b0100, 4'b0100, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 1, 0);
    check("R3", "trap at older WB", 32'(epc_we), 1);
    check("R6", "mem_we younger while trap", 32'(mem_we), 0);
    tick();
    drive(0, 0, 0, 0, 1, 0, 0);
    check("R3", "epc older", epc, 32'h300);
    check("R3", "cause older", 32'(cause), 1);
    check("R7", "rf_we flushed younger", 32'(rf_we), 0);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 0, 1, 1, 0);
      if (epc_we || rf_we || mem_we) bad++;
      tick();
    end
    check("R7", "flushed instrs silent", 32'(bad), 0);

    // R6: clean store behind a trapping older instruction
    drive(1, 32'h400, 4'b0001, 4'b0001, 0, 0, 0); tick();
    drive(1, 32'h404, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick(); tick();
    drive(0, 0, 0, 0, 0, 1, 0);
    check("R6", "clean store behind trap", 32'(mem_we), 0);
    check("R8", "trap 0x400", 32'(epc_we), 1);
    tick(); drive(0, 0, 0, 0, 0, 0, 0); tick(); tick();

    // R4: several stages flag one instruction
    drive(1, 32'h500, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 4'b0010, 4'b0000, 0, 0, 0); tick();
    drive(0, 0, 4'b0100, 4'b0100, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick(); tick();
    check("R4", "decode before execute", 32'(cause), 0);
    check("R4", "epc 0x500", epc, 32'h500);
    tick();
    drive(1, 32'h510, 4'b0001, 4'b0001, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick(); tick();
    drive(0, 0, 4'b1000, 4'b0000, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    check("R4", "fetch before memory", 32'(cause), 1);
    check("R4", "epc 0x510", epc, 32'h510);
    tick();

    // R11: return from trap
    drive(1, 32'h600, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 1);
    check("R11", "flush on eret", 32'(flush), 1);
    check("R11", "no trap on eret", 32'(epc_we), 0);
    tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R11", "redirect_vld", 32'(redirect_vld), 1);
    check("R11", "redirect_pc epc", redirect_pc, 32'h510);
    check("R11", "epc kept", epc, 32'h510);
    tick();
    drive(0, 0, 0, 0, 1, 0, 0);
    check("R11", "flushed instr no rf_we", 32'(rf_we), 0);
    tick();

    // R11: trap beats eret in same cycle
    vec_mode = 1'b1;
    drive(1, 32'h700, 4'b0001, 4'b0000, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick(); tick(); tick();
    drive(0, 0, 0, 0, 0, 0, 1);
    check("R11", "trap with eret", 32'(epc_we), 1);
    tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R11", "trap target wins", redirect_pc, 32'hC000_0000);
    check("R11", "epc trap", epc, 32'h700);
    tick();
    vec_mode = 1'b0;

    // R12: flags on bubbles ignored
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      drive(0, 32'h900, 4'b1111, 4'b1111, 0, 0, 0);
      if (epc_we || flush) bad++;
      tick();
    end
    check("R12", "bubble flags no trap", 32'(bad), 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R12", "epc untouched", epc, 32'h700);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule